// File: doc/BRIEF.md
# BCD Calendar Counter with Snapshot Reads and Buffered Writes

This block keeps wall-clock time and date as eight BCD bytes: seconds, minutes, hours, day of month, month, two-digit year, weekday and century. A prescaler counts pulses of a 32.768 kHz clock-enable. Each time it completes a full count it issues a one-second tick, and the tick advances the calendar through every carry: minute, hour, day, month, year and century.

The host does not touch the live counters directly. A snapshot strobe copies all eight bytes into a read latch, and the byte-wide read port serves data from that copy while the counters keep running. For a write, an open strobe copies the live time into an edit buffer. Byte writes then replace entries of that buffer. A commit strobe, which marks a valid stop, loads the buffer into the live counters and restarts the prescaler. An abort strobe throws the pending edit away.

After reset, which stands for a total loss of power, the counters are held still and a fail flag is raised. The first commit that carries at least one written byte clears the flag and lets time run.

Top module: `rtc_calendar_core`

## Requirements
- R1: Register index map: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 weekday, 7 century. Seconds and minutes count BCD 00 to 59, and each wrap from 59 to 00 carries into the next field.
- R2: With hour bit 7 set to 1, hours count BCD 00 to 23 in bits 5:0. Bit 7 stays set, and the step from 23 to 00 advances the day.
- R3: With hour bit 7 set to 0, hours count 1 to 12 in bits 4:0 and bit 5 marks PM. The steps are 11 AM to 12 PM, 11 PM to 12 AM and 12 to 01. Only the step into 12 AM advances the day.
- R4: The date wraps to 01 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the BCD year is divisible by 4, including year 00, and 28 days otherwise. All other months have 31 days.
- R5: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00. On that wrap the century steps from 19 to 20, and a century of 20 stays 20.
- R6: The weekday (bits 2:0 of byte 6) steps 0 through 6 and wraps to 0 each time the day advances.
- R7: A snapshot strobe copies all live bytes into the read latch. The read port returns latch contents, which do not change until the next snapshot, even while the time advances.
- R8: An open strobe copies the live time into the edit buffer, and byte writes replace buffer entries. A commit after at least one byte write loads the whole buffer, so unwritten bytes keep their copied values. An abort, or a commit with no byte written, leaves the live time unchanged.
- R9: A loading commit restarts the prescaler. The next increment comes exactly TICK_DIV enable pulses after the commit.
- R10: After reset the fail flag is 1, the counters hold the reset time 12 AM, date 01, month 01, year 00, weekday 0, century 20, and they do not advance. The first loading commit clears the flag and starts counting.
- R11: While running, the time advances by one second for every TICK_DIV enable pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, models total power loss |
| osc_en | input | 1 | One-cycle pulse per 32.768 kHz period |
| snap_i | input | 1 | Copy live time into the read latch |
| rd_addr | input | 3 | Read latch byte index |
| rd_data | output | 8 | Read latch byte |
| edit_open_i | input | 1 | Copy live time into the edit buffer |
| wr_en | input | 1 | Write one byte of the edit buffer |
| wr_addr | input | 3 | Edit buffer byte index |
| wr_data | input | 8 | Edit buffer byte value |
| commit_i | input | 1 | Valid stop: load buffer into live time |
| abort_i | input | 1 | Invalid end: discard pending edit |
| fail_o | output | 1 | Power-fail flag, counters halted while set |
| sec_tick_o | output | 1 | One-second increment strobe |

## Verification
The hardest state to reach from the ports is the final second of a century year: 11:59:59 PM on December 31 of year 99 in 12-hour mode. From there a single tick must ripple through every field at once. No amount of free running reaches it within the cycle budget. The bench therefore commits a complete buffer holding that second and then gives exactly TICK_DIV enable pulses, relying on the prescaler restart at commit. The halted state after reset is checked the same way, by pulsing the enable and taking a snapshot before any byte is committed.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int NREG     = 8;
    localparam int IDX_SEC  = 0;
    localparam int IDX_MIN  = 1;
    localparam int IDX_HOUR = 2;
    localparam int IDX_DATE = 3;
    localparam int IDX_MON  = 4;
    localparam int IDX_YEAR = 5;
    localparam int IDX_DOW  = 6;
    localparam int IDX_CENT = 7;

    typedef logic [NREG-1:0][7:0] tbank_t;

    // 12 AM, date 01, month 01, year 00, weekday 0, century 20
    localparam tbank_t RESET_TIME = {8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h12, 8'h00, 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
        return {v[7:4], v[3:0] + 4'h1};
    endfunction

    // 10*T + U is divisible by 4 exactly when 2*T + U is
    function automatic logic leap_year(input logic [7:0] yr);
        logic [4:0] s;
        s = {1'b0, yr[3:0]} + {3'b000, yr[4], 1'b0};
        return s[1:0] == 2'b00;
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int TICK_DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (restart) begin
            cnt_d = '0;
        end else if (run && osc_en) begin
            if (cnt_q == LAST) begin
                cnt_d = '0;
                tick  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rtc_time_step.sv
module rtc_time_step
    import rtc_cal_pkg::*;
(
    input  tbank_t cur,
    output tbank_t nxt
);
    logic       sec_wrap, min_wrap, day_wrap, mon_wrap, year_wrap;
    logic [7:0] hr_tmp;
    logic [7:0] h12;
    logic       pm;

    always_comb begin
        nxt       = cur;
        day_wrap  = 1'b0;
        mon_wrap  = 1'b0;
        year_wrap = 1'b0;
        hr_tmp    = '0;
        h12       = {3'b000, cur[IDX_HOUR][4:0]};
        pm        = cur[IDX_HOUR][5];

        sec_wrap = (cur[IDX_SEC] == 8'h59);
        nxt[IDX_SEC] = sec_wrap ? 8'h00 : bcd_inc(cur[IDX_SEC]);

        min_wrap = sec_wrap && (cur[IDX_MIN] == 8'h59);
        if (sec_wrap)
            nxt[IDX_MIN] = (cur[IDX_MIN] == 8'h59) ? 8'h00 : bcd_inc(cur[IDX_MIN]);

        if (min_wrap) begin
            if (cur[IDX_HOUR][7]) begin
                if (cur[IDX_HOUR][5:0] == 6'h23) begin
                    nxt[IDX_HOUR] = 8'h80;
                    day_wrap      = 1'b1;
                end else begin
                    hr_tmp        = bcd_inc({2'b00, cur[IDX_HOUR][5:0]});
                    nxt[IDX_HOUR] = {2'b10, hr_tmp[5:0]};
                end
            end else begin
                if (h12 == 8'h11) begin
                    nxt[IDX_HOUR] = {2'b00, ~pm, 5'h12};
                    day_wrap      = pm;
                end else if (h12 == 8'h12) begin
                    nxt[IDX_HOUR] = {2'b00, pm, 5'h01};
                end else begin
                    hr_tmp        = bcd_inc(h12);
                    nxt[IDX_HOUR] = {2'b00, pm, hr_tmp[4:0]};
                end
            end
        end

        if (day_wrap) begin
            nxt[IDX_DOW] = (cur[IDX_DOW][2:0] == 3'd6) ? 8'h00
                                                       : {5'b0, cur[IDX_DOW][2:0] + 3'd1};
            if (cur[IDX_DATE] == month_len(cur[IDX_MON], cur[IDX_YEAR])) begin
                nxt[IDX_DATE] = 8'h01;
                mon_wrap      = 1'b1;
            end else begin
                nxt[IDX_DATE] = bcd_inc(cur[IDX_DATE]);
            end
        end

        if (mon_wrap) begin
            if (cur[IDX_MON] == 8'h12) begin
                nxt[IDX_MON] = 8'h01;
                year_wrap    = 1'b1;
            end else begin
                nxt[IDX_MON] = bcd_inc(cur[IDX_MON]);
            end
        end

        if (year_wrap) begin
            if (cur[IDX_YEAR] == 8'h99) begin
                nxt[IDX_YEAR] = 8'h00;
                if (cur[IDX_CENT] == 8'h19) nxt[IDX_CENT] = 8'h20;
            end else begin
                nxt[IDX_YEAR] = bcd_inc(cur[IDX_YEAR]);
            end
        end
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int TICK_DIV = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic       snap_i,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       edit_open_i,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       commit_i,
    input  logic       abort_i,
    output logic       fail_o,
    output logic       sec_tick_o
);
    typedef struct packed {
        tbank_t live;
        tbank_t snap;
        tbank_t edit;
        logic   dirty;
        logic   fail;
    } core_state_t;

    core_state_t state_d, state_q;
    tbank_t      stepped;
    logic        accept;
    logic        tick;

    assign accept = commit_i && state_q.dirty;

    rtc_prescaler #(.TICK_DIV(TICK_DIV)) presc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_en (osc_en),
        .run    (!state_q.fail),
        .restart(accept),
        .tick   (tick)
    );

    rtc_time_step step_i (
        .cur(state_q.live),
        .nxt(stepped)
    );

    always_comb begin
        state_d = state_q;
        if (snap_i) state_d.snap = state_q.live;
        if (edit_open_i) begin
            state_d.edit  = state_q.live;
            state_d.dirty = 1'b0;
        end else if (abort_i) begin
            state_d.dirty = 1'b0;
        end
        if (wr_en) begin
            state_d.edit[wr_addr] = wr_data;
            state_d.dirty         = 1'b1;
        end
        if (accept) begin
            state_d.live  = state_q.edit;
            state_d.dirty = 1'b0;
            state_d.fail  = 1'b0;
        end else if (tick) begin
            state_d.live = stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.live  <= RESET_TIME;
            state_q.snap  <= RESET_TIME;
            state_q.edit  <= RESET_TIME;
            state_q.dirty <= 1'b0;
            state_q.fail  <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data    = state_q.snap[rd_addr];
    assign fail_o     = state_q.fail;
    assign sec_tick_o = tick && !accept;
endmodule

// File: rtl/rtc_calendar_checker.sv
module rtc_calendar_checker
    import rtc_cal_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   snap_i,
    input logic   edit_open_i,
    input logic   wr_en,
    input logic   commit_i,
    input logic   abort_i,
    input logic   fail_o,
    input logic   sec_tick_o,
    input logic   dirty_q,
    input tbank_t live_q,
    input tbank_t snap_q,
    input tbank_t edit_q
);
    // R1: seconds wrap from 59 to 00 on a tick
    a_r1_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick_o && live_q[IDX_SEC] == 8'h59 |=> live_q[IDX_SEC] == 8'h00);

    // R7: read latch only changes on a snapshot strobe
    a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> $stable(snap_q));

    // R8: a loading commit puts the buffer into the live time
    a_r8_commit_load: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i && dirty_q |=> live_q == $past(edit_q));

    // R8: abort leaves no pending edit
    a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i && !edit_open_i && !wr_en |=> !dirty_q);

    // R9: no increment in the cycle right after a loading commit
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i && dirty_q |=> !sec_tick_o);

    // R10: no increment while the fail flag is set
    a_r10_halted: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> !sec_tick_o);

    // R10: the flag clears only through a loading commit
    a_r10_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o && !(commit_i && dirty_q) |=> fail_o);

    // R10: live time is frozen while failed and no commit loads
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o && !(commit_i && dirty_q) |=> $stable(live_q));
endmodule

bind rtc_calendar_core rtc_calendar_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .snap_i     (snap_i),
    .edit_open_i(edit_open_i),
    .wr_en      (wr_en),
    .commit_i   (commit_i),
    .abort_i    (abort_i),
    .fail_o     (fail_o),
    .sec_tick_o (sec_tick_o),
    .dirty_q    (state_q.dirty),
    .live_q     (state_q.live),
    .snap_q     (state_q.snap),
    .edit_q     (state_q.edit)
);

// File: tb/rtc_calendar_core_tb.sv
`timescale 1ns/1ps
module rtc_calendar_core_tb_top;
    import rtc_cal_pkg::*;

    localparam int DIV = 4;
    localparam int NV  = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       snap_i = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       edit_open_i = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       commit_i = 1'b0;
    logic       abort_i = 1'b0;
    logic       fail_o;
    logic       sec_tick_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    rtc_calendar_core #(.TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .snap_i(snap_i),
        .rd_addr(rd_addr), .rd_data(rd_data), .edit_open_i(edit_open_i),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit_i(commit_i), .abort_i(abort_i), .fail_o(fail_o),
        .sec_tick_o(sec_tick_o)
    );

    // {start, expected after one second}; bytes: cent dow year mon date hour min sec
    localparam logic [127:0] VEC [NV] = '{
        {64'h20_01_23_06_15_92_34_56, 64'h20_01_23_06_15_92_34_57}, // R1 plain step
        {64'h20_06_23_06_15_A3_59_59, 64'h20_00_23_06_16_80_00_00}, // R2 R6 midnight 24h
        {64'h20_02_23_06_15_11_59_59, 64'h20_02_23_06_15_32_00_00}, // R3 11AM -> 12PM
        {64'h19_03_99_12_31_31_59_59, 64'h20_04_00_01_01_12_00_00}, // R3 R5 R6 century
        {64'h20_02_23_06_15_32_59_59, 64'h20_02_23_06_15_21_00_00}, // R3 12PM -> 1PM
        {64'h20_01_24_02_28_A3_59_59, 64'h20_02_24_02_29_80_00_00}, // R4 leap 24
        {64'h20_01_23_02_28_A3_59_59, 64'h20_02_23_03_01_80_00_00}, // R4 plain Feb
        {64'h20_01_00_02_28_A3_59_59, 64'h20_02_00_02_29_80_00_00}, // R4 year 00 leap
        {64'h20_01_23_04_30_A3_59_59, 64'h20_02_23_05_01_80_00_00}, // R4 30-day month
        {64'h20_01_23_01_30_A3_59_59, 64'h20_02_23_01_31_80_00_00}, // R4 31-day month
        {64'h20_05_99_12_31_A3_59_59, 64'h20_06_00_01_01_80_00_00}, // R5 century stays 20
        {64'h20_01_23_06_15_92_19_09, 64'h20_01_23_06_15_92_19_10}, // R1 BCD digit carry
        {64'h20_01_12_02_28_A3_59_59, 64'h20_02_12_02_29_80_00_00}, // R4 leap odd tens
        {64'h20_01_96_02_29_A3_59_59, 64'h20_02_96_03_01_80_00_00}, // R4 Feb 29 end
        {64'h20_02_23_06_15_12_59_59, 64'h20_02_23_06_15_01_00_00}, // R3 12AM -> 1AM
        {64'h20_01_23_06_15_92_59_59, 64'h20_01_23_06_15_93_00_00}  // R1 R2 hour carry
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic osc_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) osc_en = 1'b1;
            @(negedge clk) osc_en = 1'b0;
        end
    endtask

    task automatic edit_and_commit(input tbank_t val, input logic [7:0] mask);
        @(negedge clk) edit_open_i = 1'b1;
        @(negedge clk) edit_open_i = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (mask[i]) begin
                wr_en = 1'b1; wr_addr = 3'(i); wr_data = val[i];
                @(negedge clk) wr_en = 1'b0;
            end
        end
        commit_i = 1'b1;
        @(negedge clk) commit_i = 1'b0;
    endtask

    task automatic snap_read(output tbank_t val);
        @(negedge clk) snap_i = 1'b1;
        @(negedge clk) snap_i = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            rd_addr = 3'(i);
            #1 val[i] = rd_data;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tbank_t rb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check("R10 fail flag after reset", {63'b0, fail_o}, 64'd1);
        osc_pulses(3 * DIV);
        snap_read(rb);
        check("R10 halted at reset time", rb, RESET_TIME);
        edit_and_commit(RESET_TIME, 8'h00);
        check("R10 empty commit keeps flag", {63'b0, fail_o}, 64'd1);

        // table walk: R1..R6
        for (int v = 0; v < NV; v++) begin
            edit_and_commit(VEC[v][127:64], 8'hFF);
            osc_pulses(DIV);
            snap_read(rb);
            check($sformatf("R1-table vector %0d", v), rb, VEC[v][63:0]);
            if (v == 0) check("R10 flag cleared by commit", {63'b0, fail_o}, 64'd0);
        end

        // R9: prescaler restarts at commit
        edit_and_commit(64'h20_01_23_06_15_92_00_00, 8'hFF);
        osc_pulses(DIV - 1);
        snap_read(rb);
        check("R9 no step before full count", {56'b0, rb[IDX_SEC]}, 64'h00);
        osc_pulses(1);
        snap_read(rb);
        check("R9 step at full count", {56'b0, rb[IDX_SEC]}, 64'h01);
        osc_pulses(DIV - 1);
        edit_and_commit(64'h30, 8'h01);
        osc_pulses(DIV - 1);
        snap_read(rb);
        check("R9 partial count discarded", {56'b0, rb[IDX_SEC]}, 64'h30);
        osc_pulses(1);
        snap_read(rb);
        check("R9 step after restart", {56'b0, rb[IDX_SEC]}, 64'h31);

        // R11: steady rate
        osc_pulses(2 * DIV);
        snap_read(rb);
        check("R11 two seconds", rb, 64'h20_01_23_06_15_92_00_33);

        // R7: latch holds while time runs
        osc_pulses(DIV);
        rd_addr = 3'(IDX_SEC);
        #1 check("R7 latch unchanged", {56'b0, rd_data}, 64'h33);
        snap_read(rb);
        check("R7 new snapshot", {56'b0, rb[IDX_SEC]}, 64'h34);

        // R8: single byte write keeps other bytes
        edit_and_commit(64'h45_00, 8'h02);
        snap_read(rb);
        check("R8 partial write", rb, 64'h20_01_23_06_15_92_45_34);

        // R8: abort discards
        @(negedge clk) edit_open_i = 1'b1;
        @(negedge clk) edit_open_i = 1'b0;
        wr_en = 1'b1; wr_addr = 3'(IDX_SEC); wr_data = 8'h10;
        @(negedge clk) wr_en = 1'b0; abort_i = 1'b1;
        @(negedge clk) abort_i = 1'b0; commit_i = 1'b1;
        @(negedge clk) commit_i = 1'b0;
        snap_read(rb);
        check("R8 abort discards edit", rb, 64'h20_01_23_06_15_92_45_34);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule